// File: doc/BRIEF.md
# MSI capability and message generator

This block holds the message-signaled interrupt capability of a PCI-style function: a 16-bit control word, a message address (32 or 64 bits) and a message data word. Software reaches these through a small register port with a two-bit word select. Internal logic raises interrupt requests on a request vector. Instead of driving a wired interrupt line, the block turns each request into one posted memory write on a simple master interface. That write carries the programmed address and the data word, and it needs no acknowledge cycles.

Requests are held as pending bits. A pending bit is sent only while the enable bit is set. Pending bits leave in ascending index order, one write at a time, and each write is held until the master interface returns a done pulse. When more than one message is granted, the low bits of the vector field carry the request index.

Top module: `msi_msg_engine`

## Requirements
- R1: Word select 0 reads the control word. Bit 0 is the enable bit and is writable. Bits 3:1 read the capability code parameter MMC and ignore writes. Bits 6:4 read back the written grant code. Bit 7 reads the ADDR64 parameter. Bits 31:8 read zero. After reset the enable bit and the grant code are 0.
- R2: Word select 1 is the low address word. Bits 31:2 store what is written. Bits 1:0 always read zero.
- R3: Word select 2 is the high address word. With ADDR64=1 it stores writes. With ADDR64=0 it reads zero, writes to it are ignored, and outgoing addresses have bits 63:32 equal to zero.
- R4: Word select 3 is the data word. Bits 15:0 store writes. Bits 31:16 read zero.
- R5: While the enable bit is 0, no write is issued. A request that arrives then is latched as pending.
- R6: Once the enable bit is 1, pending requests are sent lowest index first.
- R7: At most one write is outstanding. mw_valid stays high with a stable mw_addr and mw_data until mw_done. It is low in the cycle after mw_done.
- R8: The grant code g gives 2^g messages (0→1, 1→2, 2→4, 3→8, 4→16, 5→32). A grant code above MMC, including the reserved codes 6 and 7, acts as MMC. The low g bits of data bits 7:0 are replaced by the request index modulo 2^g.
- R9: A request for an index that is already pending merges with it and produces a single write.
- R10: mw_addr is {high word, low word}. mw_data bits 15:8, and the vector bits above the replaced ones, equal the programmed data word. mw_data bits 31:16 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Word select: 0 control, 1 address low, 2 address high, 3 data |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected word (combinational) |
| irq_req | input | NUM_REQ | Interrupt requests, one bit per source, sampled each cycle |
| mw_valid | output | 1 | Memory-write request presented |
| mw_addr | output | 64 | Write address |
| mw_data | output | 32 | Write payload |
| mw_done | input | 1 | One-cycle pulse: the current write is finished |

## Verification
The bench builds two instances. The first uses NUM_REQ=8, MMC=3 and ADDR64=1. It exercises 64-bit addresses and vector substitution up to eight messages, including grant codes above the capability that must clamp. The second uses NUM_REQ=4, MMC=1 and ADDR64=0. It covers the ignored high address word, zero upper address bits, and clamping to two messages. Ordering, merging and gating are observed directly on the write sequence of the first instance.

// File: rtl/msi_msg_engine.sv
module msi_msg_engine #(
  parameter int NUM_REQ = 8,
  parameter logic [2:0] MMC = 3'd3,
  parameter bit ADDR64 = 1'b1,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_REQ-1:0] irq_req,
  output logic               mw_valid,
  output logic [63:0]        mw_addr,
  output logic [31:0]        mw_data,
  input  logic               mw_done
);
  logic               en;
  logic [2:0]         mme;
  logic [31:2]        addr_lo;
  logic [31:0]        addr_hi;
  logic [15:0]        data_r;
  logic [NUM_REQ-1:0] pend;
  logic [IW-1:0]      gidx;
  logic               issue;
  logic [2:0]         ecode;
  logic [7:0]         vmask, idx8;

  always_comb begin
    gidx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--)
      if (pend[i]) gidx = IW'(i);
  end

  assign issue = en && !mw_valid && (|pend);
  assign ecode = (mme > MMC) ? MMC : mme;
  assign vmask = (8'd1 << ecode) - 8'd1;
  assign idx8  = 8'(gidx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      mme     <= 3'd0;
      addr_lo <= '0;
      data_r  <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        2'd0: begin en <= cfg_wdata[0]; mme <= cfg_wdata[6:4]; end
        2'd1: addr_lo <= cfg_wdata[31:2];
        2'd3: data_r <= cfg_wdata[15:0];
        default: ;
      endcase
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n) addr_hi <= '0;
        else if (cfg_wr && cfg_sel == 2'd2) addr_hi <= cfg_wdata;
      end
    end else begin : g_nohi
      assign addr_hi = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else begin
      pend <= (pend & ~(issue ? (NUM_REQ'(1) << gidx) : '0)) | irq_req;
      if (issue) begin
        mw_valid <= 1'b1;
        mw_addr  <= {addr_hi, addr_lo, 2'b00};
        mw_data  <= {16'h0, data_r[15:8], (data_r[7:0] & ~vmask) | (idx8 & vmask)};
      end else if (mw_done) begin
        mw_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = {24'h0, 1'(ADDR64), mme, MMC, en};
      2'd1:    cfg_rdata = {addr_lo, 2'b00};
      2'd2:    cfg_rdata = addr_hi;
      default: cfg_rdata = {16'h0, data_r};
    endcase
  end
endmodule

// File: rtl/msi_msg_engine_chk.sv
module msi_msg_engine_chk #(
  parameter logic [2:0] MMC = 3'd3,
  parameter bit ADDR64 = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic        mw_valid,
  input logic [63:0] mw_addr,
  input logic [31:0] mw_data,
  input logic        mw_done
);
  p_ctrl_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel == 2'd0 |-> cfg_rdata[31:7] == {24'h0, ADDR64} && cfg_rdata[3:1] == MMC);
  p_addr_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel == 2'd1 |-> cfg_rdata[1:0] == 2'b00);
  p_narrow_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ADDR64 |-> mw_addr[63:32] == 32'h0);
  p_data_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel == 2'd3 |-> cfg_rdata[31:16] == 16'h0);
  p_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_valid) |-> $past(en));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_done |=> mw_valid && $stable(mw_addr) && $stable(mw_data));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mw_done |=> !mw_valid);
  p_payload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> mw_data[31:16] == 16'h0 && mw_addr[1:0] == 2'b00);
endmodule

bind msi_msg_engine msi_msg_engine_chk #(.MMC(MMC), .ADDR64(ADDR64)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
  .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_done(mw_done)
);

// File: tb/msi_msg_engine_tb.sv
module msi_msg_engine_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [7:0] irq_req = 0;
  logic mw_done = 0;
  logic [31:0] cfg_rdata;
  logic mw_valid;
  logic [63:0] mw_addr;
  logic [31:0] mw_data;

  logic cfg_wr2 = 0;
  logic [1:0] cfg_sel2 = 0;
  logic [31:0] cfg_wdata2 = 0;
  logic [3:0] irq_req2 = 0;
  logic mw_done2 = 0;
  logic [31:0] cfg_rdata2;
  logic mw_valid2;
  logic [63:0] mw_addr2;
  logic [31:0] mw_data2;

  int checks = 0, errors = 0, rises = 0;
  logic prev_valid = 0;

  always #10 clk = ~clk;

  msi_msg_engine #(.NUM_REQ(8), .MMC(3'd3), .ADDR64(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_req(irq_req), .mw_valid(mw_valid), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_done(mw_done));

  msi_msg_engine #(.NUM_REQ(4), .MMC(3'd1), .ADDR64(1'b0)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr2), .cfg_sel(cfg_sel2), .cfg_wdata(cfg_wdata2),
    .cfg_rdata(cfg_rdata2), .irq_req(irq_req2), .mw_valid(mw_valid2), .mw_addr(mw_addr2),
    .mw_data(mw_data2), .mw_done(mw_done2));

  always @(negedge clk) begin
    if (mw_valid && !prev_valid) rises++;
    prev_valid <= mw_valid;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk); cfg_sel = s; #1;
    check(cfg_rdata === exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic wr2(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_wr2 = 1; cfg_sel2 = s; cfg_wdata2 = d;
    @(negedge clk); cfg_wr2 = 0;
  endtask

  task automatic rd2(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk); cfg_sel2 = s; #1;
    check(cfg_rdata2 === exp, req, 64'(cfg_rdata2), 64'(exp));
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); irq_req = v;
    @(negedge clk); irq_req = 0;
  endtask

  task automatic expect_msg(input logic [63:0] ea, input logic [31:0] ed, input string req);
    int n = 0;
    logic [63:0] a0;
    logic [31:0] d0;
    while (!mw_valid && n < 50) begin @(negedge clk); n++; end
    check(mw_valid === 1'b1, req, 64'(mw_valid), 64'd1);
    check(mw_addr === ea, req, mw_addr, ea);
    check(mw_data === ed, req, 64'(mw_data), 64'(ed));
    a0 = mw_addr; d0 = mw_data;
    repeat (3) @(negedge clk);
    check(mw_valid === 1'b1 && mw_addr === a0 && mw_data === d0, "R7 hold",
          {31'h0, mw_valid, mw_data}, {31'h0, 1'b1, d0});
    mw_done = 1;
    @(negedge clk); mw_done = 0;
    check(mw_valid === 1'b0, "R7 release", 64'(mw_valid), 64'd0);
  endtask

  task automatic t_reset;
    rd(2'd0, 32'h86, "R1 reset ctrl");
    rd(2'd1, 32'h0, "R2 reset addr");
    rd(2'd3, 32'h0, "R4 reset data");
    check(mw_valid === 1'b0, "R5 reset valid", 64'(mw_valid), 64'd0);
    rd2(2'd0, 32'h02, "R1 reset ctrl narrow");
  endtask

  task automatic t_regs;
    wr(2'd0, 32'hFFFF_FF70);
    rd(2'd0, 32'hF6, "R1 ctrl write");
    wr(2'd1, 32'hFEE0_300F);
    rd(2'd1, 32'hFEE0_300C, "R2 addr low");
    wr(2'd2, 32'h0000_0001);
    rd(2'd2, 32'h0000_0001, "R3 addr high wide");
    wr(2'd3, 32'hABCD_C0A5);
    rd(2'd3, 32'h0000_C0A5, "R4 data");
    wr2(2'd2, 32'h1234_5678);
    rd2(2'd2, 32'h0, "R3 addr high ignored");
  endtask

  task automatic t_gated_merge;
    wr(2'd3, 32'h0000_8140);
    wr(2'd0, 32'h30);
    rises = 0;
    pulse(8'h24);
    pulse(8'h04);
    repeat (20) @(negedge clk);
    check(rises == 0 && mw_valid === 1'b0, "R5 gated", 64'(rises), 64'd0);
    wr(2'd0, 32'h31);
    expect_msg(64'h1_FEE0_300C, 32'h8142, "R10 R8 idx2");
    expect_msg(64'h1_FEE0_300C, 32'h8145, "R6 idx5");
    repeat (20) @(negedge clk);
    check(rises == 2, "R9 merge", 64'(rises), 64'd2);
  endtask

  task automatic t_order;
    pulse(8'h00);
    wr(2'd0, 32'h30);
    pulse(8'hFF);
    wr(2'd0, 32'h31);
    for (int i = 0; i < 8; i++)
      expect_msg(64'h1_FEE0_300C, 32'h8140 | i, "R6 ascending");
  endtask

  task automatic t_vector;
    wr(2'd3, 32'h0000_01A9);
    wr(2'd0, 32'h11);
    pulse(8'h40); expect_msg(64'h1_FEE0_300C, 32'h01A8, "R8 two messages");
    wr(2'd0, 32'h01);
    pulse(8'h40); expect_msg(64'h1_FEE0_300C, 32'h01A9, "R8 one message");
    wr(2'd0, 32'h71);
    pulse(8'h40); expect_msg(64'h1_FEE0_300C, 32'h01AE, "R8 clamp reserved");
    wr(2'd0, 32'h21);
    pulse(8'h80); expect_msg(64'h1_FEE0_300C, 32'h01AB, "R8 four messages");
  endtask

  task automatic t_narrow;
    int n = 0;
    wr2(2'd1, 32'hFEE0_1004);
    wr2(2'd3, 32'h0000_00FF);
    wr2(2'd0, 32'h31);
    @(negedge clk); irq_req2 = 4'h4;
    @(negedge clk); irq_req2 = 0;
    while (!mw_valid2 && n < 50) begin @(negedge clk); n++; end
    check(mw_addr2 === 64'h0000_0000_FEE0_1004, "R3 narrow address", mw_addr2, 64'h0000_0000_FEE0_1004);
    check(mw_data2 === 32'h0000_00FE, "R8 narrow clamp", 64'(mw_data2), 64'hFE);
    mw_done2 = 1;
    @(negedge clk); mw_done2 = 0;
    check(mw_valid2 === 1'b0, "R7 narrow release", 64'(mw_valid2), 64'd0);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_gated_merge;
    t_order;
    t_vector;
    t_narrow;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule